// File: doc/BRIEF.md
# Latency-Window Pop Controller

This block sits on the read side of a time-ordered pipeline FIFO. The FIFO carries data words and, once per time period, a marker word. A free-running time counter gives real time. A read-position counter counts the marker words the block has popped. The difference between the two is the lag of the FIFO read side, in periods. While no trigger is pending, the block pops just enough words to hold that lag at a fixed latency. A popped word in this state is discarded.

When a trigger arrives, popping stops and the current read position is saved. The block then waits for the readout token of a daisy chain. Once the token arrives, it pops forward through a window of a fixed number of periods. Every word it pops in the window goes to the event buffer. The block then hands the token to the next stage in the chain and goes back to tracking the latency.

All differences between counters are taken modulo the read-position width, so both counters may wrap freely.

Top module: `latwin_pop_ctrl`

## Requirements
- R1: With rst_ni low, and in the first cycle after its release, fifo_pop_o, evb_push_o, token_o and trig_drop_o are all 0.
- R2: After reset the block pops nothing until lag = (time >> TICK_LOG2) − markers popped, taken modulo 2^(TS_W−TICK_LOG2), exceeds LAT_PER. Tracking starts on the next clock edge, and the first pop is one cycle after the lag first exceeds LAT_PER.
- R3: A word is a marker when its top ADDR_W bits are all zero. Each popped marker advances the read position by one on the clock edge at which it is popped.
- R4: While tracking, fifo_pop_o is 1 exactly when lag > LAT_PER and the FIFO is not empty. The lag therefore settles at LAT_PER or LAT_PER+1, and evb_push_o stays 0.
- R5: fifo_pop_o is 0 in every cycle in which fifo_empty_i is 1, whatever the state. Popping resumes in the first cycle in which the FIFO is non-empty again.
- R6: A trigger while tracking blocks the pop in its own cycle and saves the read position. No word is popped or pushed until token_i arrives.
- R7: On the token, the block pops every word up to and including the WIN_PER-th marker after the saved position. Each of these words is pushed with evb_word_o equal to the popped word. token_o then pulses for one cycle, two cycles after the last push.
- R8: After the outgoing token, the block tracks the latency again. It catches up without pushing, until the lag is back at LAT_PER or LAT_PER+1.
- R9: A trigger that arrives in any state other than tracking changes neither the state nor the pops. It sets trig_drop_o, which stays 1 until reset.
- R10: A token_i pulse that arrives while no trigger is waiting for it appears on token_o one cycle later.
- R11: Tracking stays correct across wrap-around of both the time counter and the read-position counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_empty_i | input | 1 | FIFO has no word at its head |
| fifo_word_i | input | ADDR_W+PAY_W | Head word of the FIFO (show-ahead) |
| fifo_pop_o | output | 1 | Consume the head word at this clock edge |
| trig_i | input | 1 | Trigger accept pulse |
| token_i | input | 1 | Incoming readout token |
| token_o | output | 1 | Outgoing readout token, one-cycle pulse |
| evb_push_o | output | 1 | Write evb_word_o into the event buffer |
| evb_word_o | output | ADDR_W+PAY_W | Word for the event buffer |
| trig_drop_o | output | 1 | Sticky flag: a trigger was ignored |

## Verification
The bench builds the block with an 8-bit time counter, 4 cycles per period, a latency of 6 periods and a window of 3 periods. The read-position counter is then 6 bits wide. With these values the time counter wraps every 256 cycles and the read position wraps after 64 markers, so several wraps of both fit into a few hundred cycles. The start-up delay comes out at 29 cycles, and a full hold-and-drain cycle completes in tens of cycles. The FIFO model puts a marker at every third word. Popping can therefore outrun the time base, and the settled lag, the catch-up after a hold and the exact drain length all become observable.

// File: rtl/latwin_pkg.sv
package latwin_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_TRACK = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DRAIN = 2'd3
  } latwin_state_e;
endpackage

// File: rtl/latwin_time_base.sv
module latwin_time_base #(
  parameter int TS_W      = 12,
  parameter int TICK_LOG2 = 4,
  localparam int PER_W    = TS_W - TICK_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PER_W-1:0] per_o
);
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= '0;
    else         ts_q <= ts_q + 1'b1;
  end

  assign per_o = ts_q[TS_W-1:TICK_LOG2];
endmodule

// File: rtl/latwin_read_pos.sv
module latwin_read_pos #(
  parameter int ADDR_W  = 4,
  parameter int PAY_W   = 5,
  parameter int TP_W    = 8,
  localparam int WORD_W = ADDR_W + PAY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [TP_W-1:0]   tp_o
);
  logic is_marker;
  logic [TP_W-1:0] tp_q;

  assign is_marker = (word_i[WORD_W-1 -: ADDR_W] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tp_q <= '0;
    else if (pop_i && is_marker) tp_q <= tp_q + 1'b1;
  end

  assign tp_o = tp_q;

  // R3
  tp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && is_marker) |=> $stable(tp_o));
endmodule

// File: rtl/latwin_pop_fsm.sv
module latwin_pop_fsm
  import latwin_pkg::*;
#(
  parameter int TP_W    = 8,
  parameter int LAT_PER = 64,
  parameter int WIN_PER = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TP_W-1:0] per_i,
  input  logic [TP_W-1:0] tp_i,
  input  logic            fifo_empty_i,
  input  logic            trig_i,
  input  logic            token_i,
  output logic            pop_o,
  output logic            push_o,
  output logic            token_o,
  output logic            drop_o
);
  localparam logic [TP_W-1:0] LAT_C = TP_W'(LAT_PER);
  localparam logic [TP_W-1:0] WIN_C = TP_W'(WIN_PER);

  latwin_state_e   state_q, state_d;
  logic [TP_W-1:0] trig_pos_q;
  logic [TP_W-1:0] lag, ahead;
  logic            drain_done, token_q, drop_q;

  always_comb begin
    lag        = per_i - tp_i;
    ahead      = tp_i - trig_pos_q;
    pop_o      = 1'b0;
    state_d    = state_q;
    drain_done = 1'b0;
    unique case (state_q)
      ST_INIT: begin
        if (lag > LAT_C) state_d = ST_TRACK;
      end
      ST_TRACK: begin
        pop_o = !fifo_empty_i && !trig_i && (lag > LAT_C);
        if (trig_i) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (token_i) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        pop_o = !fifo_empty_i && (ahead < WIN_C);
        if (ahead >= WIN_C) begin
          state_d    = ST_TRACK;
          drain_done = 1'b1;
        end
      end
      default: state_d = ST_INIT;
    endcase
  end

  assign push_o = pop_o && (state_q == ST_DRAIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_INIT;
      trig_pos_q <= '0;
      token_q    <= 1'b0;
      drop_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_TRACK && trig_i) trig_pos_q <= tp_i;
      token_q <= drain_done || (token_i && state_q != ST_HOLD);
      drop_q  <= drop_q || (trig_i && state_q != ST_TRACK);
    end
  end

  assign token_o = token_q;
  assign drop_o  = drop_q;

  // R5
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty_i |-> !pop_o);
  // R2
  init_no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INIT) |-> !pop_o);
  // R6
  hold_no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> !pop_o);
  // R6
  trig_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRACK && trig_i) |=> (state_q == ST_HOLD && trig_pos_q == $past(tp_i)));
  // R7
  drain_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && ahead >= WIN_C) |=> token_o);
  // R9
  drop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> drop_o);
endmodule

// File: rtl/latwin_pop_ctrl.sv
module latwin_pop_ctrl #(
  parameter int TS_W      = 12,
  parameter int TICK_LOG2 = 4,
  parameter int ADDR_W    = 4,
  parameter int PAY_W     = 5,
  parameter int LAT_PER   = 64,
  parameter int WIN_PER   = 16,
  localparam int TP_W     = TS_W - TICK_LOG2,
  localparam int WORD_W   = ADDR_W + PAY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] fifo_word_i,
  output logic              fifo_pop_o,
  input  logic              trig_i,
  input  logic              token_i,
  output logic              token_o,
  output logic              evb_push_o,
  output logic [WORD_W-1:0] evb_word_o,
  output logic              trig_drop_o
);
  logic [TP_W-1:0] per;
  logic [TP_W-1:0] tp;
  logic            pop;

  latwin_time_base #(.TS_W(TS_W), .TICK_LOG2(TICK_LOG2)) u_time (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .per_o (per)
  );

  latwin_read_pos #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .TP_W(TP_W)) u_rpos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pop_i (pop),
    .word_i(fifo_word_i),
    .tp_o  (tp)
  );

  latwin_pop_fsm #(.TP_W(TP_W), .LAT_PER(LAT_PER), .WIN_PER(WIN_PER)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .per_i       (per),
    .tp_i        (tp),
    .fifo_empty_i(fifo_empty_i),
    .trig_i      (trig_i),
    .token_i     (token_i),
    .pop_o       (pop),
    .push_o      (evb_push_o),
    .token_o     (token_o),
    .drop_o      (trig_drop_o)
  );

  assign fifo_pop_o = pop;
  assign evb_word_o = fifo_word_i;

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!fifo_pop_o && !evb_push_o && !token_o && !trig_drop_o));
endmodule

// File: tb/latwin_pop_ctrl_tb_top.sv
`timescale 1ns/1ps
module latwin_pop_ctrl_tb_top;
  localparam int TS_W = 8, TICK = 2, ADDR_W = 3, PAY_W = 5, LAT = 6, WIN = 3;
  localparam int WORD_W = ADDR_W + PAY_W;

  logic clk = 1'b0, rst_n = 1'b0, fifo_empty = 1'b1, trig = 1'b0, token = 1'b0;
  logic [WORD_W-1:0] fifo_word, evb_word;
  logic fifo_pop, token_out, evb_push, drop;

  int h = 0, tp_m = 0, cyc = 0, pop_tot = 0;
  int push_tot = 0, push_bad = 0, last_push_cyc = 0, tok_tot = 0, tok_cyc = 0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  function automatic logic [WORD_W-1:0] word_of(int i);
    return {3'(i % 3), 5'(i)};
  endfunction

  function automatic int lag_now();
    return ((cyc >> TICK) - tp_m) & 63;
  endfunction

  assign fifo_word = word_of(h);

  latwin_pop_ctrl #(.TS_W(TS_W), .TICK_LOG2(TICK), .ADDR_W(ADDR_W), .PAY_W(PAY_W),
                    .LAT_PER(LAT), .WIN_PER(WIN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_empty_i(fifo_empty), .fifo_word_i(fifo_word),
    .fifo_pop_o(fifo_pop), .trig_i(trig), .token_i(token), .token_o(token_out),
    .evb_push_o(evb_push), .evb_word_o(evb_word), .trig_drop_o(drop));

  // FIFO and time model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; h <= 0; tp_m <= 0;
    end else begin
      cyc <= cyc + 1;
      if (fifo_pop) begin
        h <= h + 1;
        pop_tot <= pop_tot + 1;
        if (h % 3 == 0) tp_m <= tp_m + 1;
      end
      if (evb_push) begin
        push_tot <= push_tot + 1;
        last_push_cyc <= cyc;
        if (evb_word != word_of(h)) push_bad <= push_bad + 1;
      end
      if (token_out) begin
        tok_tot <= tok_tot + 1;
        tok_cyc <= cyc;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trig = 1'b0; token = 1'b0; fifo_empty = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; fifo_empty = 1'b0;
    @(negedge clk);
    chk(!fifo_pop && !evb_push && !token_out && !drop, "R1", "outputs in reset",
        {fifo_pop, evb_push, token_out, drop}, 0);
    rst_n = 1'b1;
    chk(!fifo_pop && !evb_push && !token_out && !drop, "R1", "outputs after release",
        {fifo_pop, evb_push, token_out, drop}, 0);
  endtask

  task automatic startup_walk(string req);
    int early = 0, first = 0;
    for (int k = 0; k < 36; k++) begin
      if (cyc < 29 && fifo_pop) early++;
      if (cyc == 29) first = fifo_pop;
      @(negedge clk);
    end
    chk(early == 0, req, "pops before latency reached", early, 0);
    chk(first == 1, req, "first pop at cycle 29", first, 1);
  endtask

  task automatic t_startup();
    do_reset();
    startup_walk("R2");
  endtask

  task automatic t_track();
    int bad_lag = 0, bad_pop = 0, bad_push = 0, p0 = pop_tot;
    for (int k = 0; k < 700; k++) begin
      @(negedge clk);
      if (lag_now() < LAT || lag_now() > LAT + 1) bad_lag++;
      if (fifo_pop != (lag_now() > LAT)) bad_pop++;
      if (evb_push) bad_push++;
    end
    chk(bad_lag == 0, "R4", "lag outside LAT..LAT+1", bad_lag, 0);
    chk(bad_pop == 0, "R4", "pop not equal lag>LAT", bad_pop, 0);
    chk(bad_push == 0, "R4", "push while tracking", bad_push, 0);
    // R11: 700 cycles wraps the time counter and the read position several times
    chk(pop_tot - p0 > 200, "R11", "pops across wrap", pop_tot - p0, 201);
    chk(tp_m > 64, "R3", "markers counted past wrap", tp_m, 65);
  endtask

  task automatic t_empty();
    int bad = 0;
    @(negedge clk);
    fifo_empty = 1'b1;
    #1;
    for (int k = 0; k < 20; k++) begin
      if (fifo_pop) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R5", "pop while empty", bad, 0);
    chk(lag_now() >= 10, "R5", "lag grew while empty", lag_now(), 10);
    fifo_empty = 1'b0;
    #1;
    chk(fifo_pop == 1'b1, "R5", "pop resumes when non-empty", fifo_pop, 1);
    repeat (100) @(negedge clk);
    chk(lag_now() >= LAT && lag_now() <= LAT + 1, "R4", "lag settled after empty", lag_now(), LAT);
  endtask

  task automatic t_token_fwd();
    @(negedge clk);
    token = 1'b1;
    @(negedge clk);
    token = 1'b0;
    chk(token_out == 1'b1, "R10", "token forwarded", token_out, 1);
    @(negedge clk);
    chk(token_out == 1'b0, "R10", "token pulse ends", token_out, 0);
  endtask

  task automatic t_trigger();
    int bad_pop = 0, p0, t0, h0, n, cnt, i, p1, pt;
    @(negedge clk);
    trig = 1'b1;
    #1;
    chk(fifo_pop == 1'b0, "R6", "no pop in trigger cycle", fifo_pop, 0);
    @(negedge clk);
    trig = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (k == 6) trig = 1'b1;
      if (k == 7) trig = 1'b0;
      if (fifo_pop || evb_push) bad_pop++;
      @(negedge clk);
    end
    chk(bad_pop == 0, "R6", "pop or push while holding", bad_pop, 0);
    chk(drop == 1'b1, "R9", "second trigger flagged", drop, 1);
    p0 = push_tot; t0 = tok_tot; h0 = h;
    cnt = 0; i = h0;
    while (cnt < WIN) begin
      if (i % 3 == 0) cnt++;
      i++;
    end
    n = i - h0;
    token = 1'b1;
    @(negedge clk);
    token = 1'b0;
    repeat (40) @(negedge clk);
    chk(push_tot - p0 == n, "R7", "words pushed in window", push_tot - p0, n);
    chk(push_bad == 0, "R7", "pushed word mismatch", push_bad, 0);
    chk(tok_tot - t0 == 1, "R7", "outgoing token pulses", tok_tot - t0, 1);
    chk(tok_cyc == last_push_cyc + 2, "R7", "token cycle after last push", tok_cyc, last_push_cyc + 2);
    p1 = push_tot; pt = pop_tot;
    repeat (150) @(negedge clk);
    chk(push_tot == p1, "R8", "no push after drain", push_tot - p1, 0);
    chk(pop_tot > pt, "R8", "tracking pops resumed", pop_tot - pt, 1);
    chk(lag_now() >= LAT && lag_now() <= LAT + 1, "R8", "lag back at latency", lag_now(), LAT);
  endtask

  task automatic t_drop_init();
    do_reset();
    repeat (5) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(drop == 1'b1, "R9", "trigger during start-up flagged", drop, 1);
    startup_walk("R9");
    repeat (50) @(negedge clk);
    chk(drop == 1'b1, "R9", "drop flag sticky", drop, 1);
    chk(evb_push == 1'b0 && lag_now() <= LAT + 1, "R9", "state unaffected", lag_now(), LAT);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_startup();
    t_track();
    t_empty();
    t_token_fwd();
    t_trigger();
    t_drop_init();
    finish_run();
  end
endmodule